// File: doc/BRIEF.md
# Trap Return Status Update Unit

This unit produces the status state a processor core holds after it retires one of three return instructions: a supervisor return, a machine return, or a return from a resumable non-maskable interrupt. The core presents its current machine status word, hypervisor status word, virtual-supervisor status word, the current virtualization flag, the saved target level and virtualization of the interrupt handler, and a handful of configuration inputs. One strobe bit per return type selects the update. On the clock edge that sees the strobe, the unit registers the new status words together with the privilege level and virtualization mode the core resumes in.

The words that come out follow the fixed bit layout given in the requirements. The unit also clears a supervisor double-trap flag when that feature is switched on. Which copy of the flag it clears depends on the level being entered and on whether that level is virtualized. When no strobe is active, every output register keeps its value.

Top module: `trap_ret_unit`

## Requirements
- R1: While reset is asserted, all three status outputs read zero, the privilege output reads machine (2'b11) and the virtualization output reads 0. Levels are encoded user 2'b00, supervisor 2'b01, machine 2'b11.
- R2: With all three strobe bits low (ret_i[0] supervisor return, ret_i[1] machine return, ret_i[2] interrupt return), every output keeps its value whatever the other inputs do.
- R3: A supervisor return copies the previous-enable bit (bit 5) into the supervisor enable bit (bit 1), sets bit 5, and clears the previous-level bit (bit 8). The new level is supervisor when bit 8 was 1 and user otherwise. The new virtualization is 1 if the core was virtualized, or if the hypervisor is present and the saved virtualization bit (bit 7 of the hypervisor word) is 1. With the hypervisor present that bit is cleared; without it the hypervisor word is unchanged.
- R4: With the double-trap feature on, a supervisor return clears the double-trap bit (bit 24) of the machine word.
- R5: With the double-trap feature and the hypervisor both on, a supervisor return clears bit 24 of the virtual-supervisor word only when the core is not virtualized, hypervisor bit 7 is 1 and machine bit 8 is 0. Otherwise that word is unchanged.
- R6: A machine return copies bit 7 into the machine enable bit (bit 3) and sets bit 7. It writes the previous-level field (bits 12:11) to user when user mode exists and to machine otherwise, and clears the saved virtualization bit (bit 39). The new level is the old bits 12:11. The new virtualization is 1 only when the hypervisor is present, bit 39 was 1 and that level is below machine.
- R7: An interrupt return takes its level from nmi_prv_i. Its virtualization is nmi_pv_i, gated by hypervisor presence and by a level below machine. It touches no other machine-word field except those named in R8 and R10.
- R8: With the double-trap feature on, a machine or interrupt return clears machine bit 24 when the target is user, or when the target is virtualized supervisor or virtualized user.
- R9: With the double-trap feature on, a machine or interrupt return into virtualized user also clears bit 24 of the virtual-supervisor word; other targets leave that word unchanged.
- R10: The modify-privilege bit (bit 17) is cleared by a machine or interrupt return whose target is below machine. A supervisor return clears it only when the version-1.12 input is 1.
- R11: With the double-trap feature off, no return changes bit 24 of either word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ret_i | input | 3 | One-hot return strobe: [0] supervisor, [1] machine, [2] interrupt |
| virt_i | input | 1 | Core currently virtualized |
| mstatus_i | input | XLEN | Current machine status word |
| hstatus_i | input | XLEN | Current hypervisor status word |
| vsstatus_i | input | XLEN | Current virtual-supervisor status word |
| nmi_prv_i | input | 2 | Level saved by the interrupt handler entry |
| nmi_pv_i | input | 1 | Virtualization saved by the interrupt handler entry |
| cfg_hyp_i | input | 1 | Hypervisor present |
| cfg_user_i | input | 1 | User mode present |
| cfg_dbltrp_i | input | 1 | Supervisor double-trap feature enabled |
| cfg_v112_i | input | 1 | Privileged version 1.12 or later |
| mstatus_o | output | XLEN | Registered machine status word |
| hstatus_o | output | XLEN | Registered hypervisor status word |
| vsstatus_o | output | XLEN | Registered virtual-supervisor status word |
| priv_o | output | 2 | Registered privilege level |
| virt_o | output | 1 | Registered virtualization mode |

## Verification
The double-trap clear and the modify-privilege clear act on the same machine word in the same cycle. Both are decided from one target level, which is itself being restored at that edge. The bench provokes this by presenting words with the double-trap bit, the modify-privilege bit and the saved-state fields all set, and then returning to each of user, supervisor, virtualized supervisor, virtualized user and machine. Each result is judged by comparing the whole registered word, so a clear that lands on the wrong copy, or one that is skipped, shows up next to the correct restore of the enable and level fields.

// File: rtl/trs_pkg.sv
package trs_pkg;
   localparam logic [1:0] LVL_USER  = 2'b00;
   localparam logic [1:0] LVL_SUPER = 2'b01;
   localparam logic [1:0] LVL_MACH  = 2'b11;

   localparam int B_SIE  = 1;
   localparam int B_MIE  = 3;
   localparam int B_SPIE = 5;
   localparam int B_MPIE = 7;
   localparam int B_SPP  = 8;
   localparam int B_MPP  = 11;
   localparam int B_MPRV = 17;
   localparam int B_SDT  = 24;
   localparam int B_MPV  = 39;
   localparam int B_SPV  = 7;

   localparam int RET_S  = 0;
   localparam int RET_M  = 1;
   localparam int RET_N  = 2;
   localparam int NUM_RET = 3;
endpackage

// File: rtl/trs_target.sv
module trs_target
   import trs_pkg::*;
(
   input  logic [NUM_RET-1:0] ret_i,
   input  logic               virt_i,
   input  logic               spp_i,
   input  logic [1:0]         mpp_i,
   input  logic               mpv_i,
   input  logic               spv_i,
   input  logic [1:0]         nmi_prv_i,
   input  logic               nmi_pv_i,
   input  logic               hyp_i,
   output logic [1:0]         lvl_o,
   output logic               virt_o
);
   always_comb begin
      lvl_o  = LVL_MACH;
      virt_o = 1'b0;
      if (ret_i[RET_S]) begin
         lvl_o  = spp_i ? LVL_SUPER : LVL_USER;
         virt_o = virt_i | (hyp_i & spv_i);
      end else if (ret_i[RET_M]) begin
         lvl_o  = mpp_i;
         virt_o = hyp_i & mpv_i & (mpp_i != LVL_MACH);
      end else if (ret_i[RET_N]) begin
         lvl_o  = nmi_prv_i;
         virt_o = hyp_i & nmi_pv_i & (nmi_prv_i != LVL_MACH);
      end
   end
endmodule

// File: rtl/trs_sdt_ctl.sv
module trs_sdt_ctl
   import trs_pkg::*;
#(
   parameter bit SDT_IMPL = 1'b1
)(
   input  logic [NUM_RET-1:0] ret_i,
   input  logic               en_i,
   input  logic               hyp_i,
   input  logic               virt_i,
   input  logic               spv_i,
   input  logic               spp_i,
   input  logic [1:0]         lvl_i,
   input  logic               tvirt_i,
   output logic               clr_m_o,
   output logic               clr_vs_o
);
   generate
      if (SDT_IMPL) begin : g_sdt
         logic is_mx, to_user, to_vsu, sret_vu;
         assign is_mx   = ret_i[RET_M] | ret_i[RET_N];
         assign to_user = (lvl_i == LVL_USER);
         assign to_vsu  = tvirt_i & ((lvl_i == LVL_USER) | (lvl_i == LVL_SUPER));
         assign sret_vu = hyp_i & ~virt_i & spv_i & ~spp_i;
         assign clr_m_o  = en_i & (ret_i[RET_S] | (is_mx & (to_user | to_vsu)));
         assign clr_vs_o = en_i & ((ret_i[RET_S] & sret_vu) |
                                   (is_mx & tvirt_i & to_user));
      end else begin : g_nosdt
         logic unused_sdt;
         assign unused_sdt = ^{ret_i, en_i, hyp_i, virt_i, spv_i, spp_i, lvl_i, tvirt_i};
         assign clr_m_o  = 1'b0;
         assign clr_vs_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/trs_word_next.sv
module trs_word_next
   import trs_pkg::*;
#(
   parameter int XLEN = 64
)(
   input  logic [NUM_RET-1:0] ret_i,
   input  logic [XLEN-1:0]    mstatus_i,
   input  logic [XLEN-1:0]    hstatus_i,
   input  logic [XLEN-1:0]    vsstatus_i,
   input  logic [1:0]         lvl_i,
   input  logic               hyp_i,
   input  logic               user_i,
   input  logic               v112_i,
   input  logic               clr_m_i,
   input  logic               clr_vs_i,
   output logic [XLEN-1:0]    mstatus_o,
   output logic [XLEN-1:0]    hstatus_o,
   output logic [XLEN-1:0]    vsstatus_o
);
   generate
      if (XLEN < B_MPV + 1) begin : g_bad_xlen
         $error("trs_word_next: XLEN too small for status layout");
      end
   endgenerate

   logic below_m;
   assign below_m = (lvl_i != LVL_MACH);

   always_comb begin
      mstatus_o  = mstatus_i;
      hstatus_o  = hstatus_i;
      vsstatus_o = vsstatus_i;
      if (ret_i[RET_S]) begin
         mstatus_o[B_SIE]  = mstatus_i[B_SPIE];
         mstatus_o[B_SPIE] = 1'b1;
         mstatus_o[B_SPP]  = 1'b0;
         if (v112_i) mstatus_o[B_MPRV] = 1'b0;
         if (hyp_i)  hstatus_o[B_SPV]  = 1'b0;
      end
      if (ret_i[RET_M]) begin
         mstatus_o[B_MIE]      = mstatus_i[B_MPIE];
         mstatus_o[B_MPIE]     = 1'b1;
         mstatus_o[B_MPP +: 2] = user_i ? LVL_USER : LVL_MACH;
         mstatus_o[B_MPV]      = 1'b0;
         if (below_m) mstatus_o[B_MPRV] = 1'b0;
      end
      if (ret_i[RET_N]) begin
         if (below_m) mstatus_o[B_MPRV] = 1'b0;
      end
      if (clr_m_i)  mstatus_o[B_SDT]  = 1'b0;
      if (clr_vs_i) vsstatus_o[B_SDT] = 1'b0;
   end
endmodule

// File: rtl/trap_ret_unit.sv
module trap_ret_unit
   import trs_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter bit SDT_IMPL = 1'b1
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [2:0]        ret_i,
   input  logic              virt_i,
   input  logic [XLEN-1:0]   mstatus_i,
   input  logic [XLEN-1:0]   hstatus_i,
   input  logic [XLEN-1:0]   vsstatus_i,
   input  logic [1:0]        nmi_prv_i,
   input  logic              nmi_pv_i,
   input  logic              cfg_hyp_i,
   input  logic              cfg_user_i,
   input  logic              cfg_dbltrp_i,
   input  logic              cfg_v112_i,
   output logic [XLEN-1:0]   mstatus_o,
   output logic [XLEN-1:0]   hstatus_o,
   output logic [XLEN-1:0]   vsstatus_o,
   output logic [1:0]        priv_o,
   output logic              virt_o
);
   localparam int RET_W = NUM_RET;

   generate
      if (RET_W != 3) begin : g_bad_ret
         $error("trap_ret_unit: strobe width mismatch");
      end
   endgenerate

   logic [1:0]      tgt_lvl;
   logic            tgt_virt;
   logic            clr_m, clr_vs;
   logic [XLEN-1:0] m_nx, h_nx, vs_nx;
   logic            any_ret;

   assign any_ret = |ret_i;

   trs_target u_target (
      .ret_i     (ret_i),
      .virt_i    (virt_i),
      .spp_i     (mstatus_i[B_SPP]),
      .mpp_i     (mstatus_i[B_MPP +: 2]),
      .mpv_i     (mstatus_i[B_MPV]),
      .spv_i     (hstatus_i[B_SPV]),
      .nmi_prv_i (nmi_prv_i),
      .nmi_pv_i  (nmi_pv_i),
      .hyp_i     (cfg_hyp_i),
      .lvl_o     (tgt_lvl),
      .virt_o    (tgt_virt)
   );

   trs_sdt_ctl #(.SDT_IMPL(SDT_IMPL)) u_sdt (
      .ret_i    (ret_i),
      .en_i     (cfg_dbltrp_i),
      .hyp_i    (cfg_hyp_i),
      .virt_i   (virt_i),
      .spv_i    (hstatus_i[B_SPV]),
      .spp_i    (mstatus_i[B_SPP]),
      .lvl_i    (tgt_lvl),
      .tvirt_i  (tgt_virt),
      .clr_m_o  (clr_m),
      .clr_vs_o (clr_vs)
   );

   trs_word_next #(.XLEN(XLEN)) u_next (
      .ret_i      (ret_i),
      .mstatus_i  (mstatus_i),
      .hstatus_i  (hstatus_i),
      .vsstatus_i (vsstatus_i),
      .lvl_i      (tgt_lvl),
      .hyp_i      (cfg_hyp_i),
      .user_i     (cfg_user_i),
      .v112_i     (cfg_v112_i),
      .clr_m_i    (clr_m),
      .clr_vs_i   (clr_vs),
      .mstatus_o  (m_nx),
      .hstatus_o  (h_nx),
      .vsstatus_o (vs_nx)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mstatus_o  <= '0;
         hstatus_o  <= '0;
         vsstatus_o <= '0;
         priv_o     <= LVL_MACH;
         virt_o     <= 1'b0;
      end else if (any_ret) begin
         mstatus_o  <= m_nx;
         hstatus_o  <= h_nx;
         vsstatus_o <= vs_nx;
         priv_o     <= tgt_lvl;
         virt_o     <= tgt_virt;
      end
   end

   AST_ONE_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(ret_i)); // R2
   AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_i == '0) |=> ($stable(mstatus_o) && $stable(vsstatus_o) && $stable(priv_o) && $stable(virt_o))); // R2
   AST_SRET_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ret_i[RET_S] |=> (mstatus_o[B_SPIE] && !mstatus_o[B_SPP] && priv_o != LVL_MACH)); // R3
   AST_SRET_SDT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_i[RET_S] && cfg_dbltrp_i) |=> !mstatus_o[B_SDT]); // R4
   AST_MRET_MPV: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ret_i[RET_M] |=> (!mstatus_o[B_MPV] && mstatus_o[B_MPIE])); // R6
   AST_MX_MPRV: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((ret_i[RET_M] || ret_i[RET_N]) && mstatus_i[B_MPRV]) |=> (mstatus_o[B_MPRV] == (priv_o == LVL_MACH))); // R10
   AST_SDT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (any_ret && !cfg_dbltrp_i) |=> (mstatus_o[B_SDT] == $past(mstatus_i[B_SDT]) &&
                                      vsstatus_o[B_SDT] == $past(vsstatus_i[B_SDT]))); // R11
   AST_VU_SDT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((ret_i[RET_M] || ret_i[RET_N]) && cfg_dbltrp_i) |=>
         ((virt_o && priv_o == LVL_USER) ? !vsstatus_o[B_SDT] : (vsstatus_o[B_SDT] == $past(vsstatus_i[B_SDT])))); // R9
endmodule

// File: tb/trap_ret_unit_test.sv
`timescale 1ns/1ps
module trap_ret_unit_test;
   localparam int XLEN = 64;
   localparam int P_SIE = 1, P_MIE = 3, P_SPIE = 5, P_MPIE = 7, P_SPP = 8, P_MPP = 11;
   localparam int P_MPRV = 17, P_SDT = 24, P_MPV = 39, P_SPV = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] ret = '0;
   logic virt = 0, npv = 0, hyp = 0, usr = 0, dbl = 0, v112 = 0;
   logic [XLEN-1:0] ms = '0, hs = '0, vs = '0;
   logic [1:0] nprv = '0;
   logic [XLEN-1:0] ms_o, hs_o, vs_o;
   logic [1:0] prv_o;
   logic virt_o;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   trap_ret_unit #(.XLEN(XLEN)) uut (
      .clk_i(clk), .rst_ni(rst_n), .ret_i(ret), .virt_i(virt),
      .mstatus_i(ms), .hstatus_i(hs), .vsstatus_i(vs),
      .nmi_prv_i(nprv), .nmi_pv_i(npv), .cfg_hyp_i(hyp), .cfg_user_i(usr),
      .cfg_dbltrp_i(dbl), .cfg_v112_i(v112),
      .mstatus_o(ms_o), .hstatus_o(hs_o), .vsstatus_o(vs_o),
      .priv_o(prv_o), .virt_o(virt_o));

   function automatic logic [XLEN-1:0] b(int n);
      return {{(XLEN-1){1'b0}}, 1'b1} << n;
   endfunction

   task automatic expect_all(string tag, logic [XLEN-1:0] em, logic [XLEN-1:0] eh,
                             logic [XLEN-1:0] ev, logic [1:0] ep, logic evt);
      checks++;
      if (ms_o !== em || hs_o !== eh || vs_o !== ev || prv_o !== ep || virt_o !== evt) begin
         errors++;
         $display("FAIL %s: actual m=%h h=%h vs=%h prv=%b virt=%b expected m=%h h=%h vs=%h prv=%b virt=%b",
                  tag, ms_o, hs_o, vs_o, prv_o, virt_o, em, eh, ev, ep, evt);
      end
   endtask

   task automatic fire(logic [2:0] r, logic vi, logic [XLEN-1:0] m, logic [XLEN-1:0] h,
                       logic [XLEN-1:0] v, logic [1:0] np, logic nv,
                       logic c_h, logic c_u, logic c_d, logic c_v);
      @(negedge clk);
      ret = r; virt = vi; ms = m; hs = h; vs = v; nprv = np; npv = nv;
      hyp = c_h; usr = c_u; dbl = c_d; v112 = c_v;
      @(negedge clk);
      ret = '0;
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      expect_all("R1 reset values", '0, '0, '0, 2'b11, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      expect_all("R1 after release", '0, '0, '0, 2'b11, 1'b0);
   endtask

   task automatic t_sret_basic;
      fire(3'b001, 0, b(P_SPIE)|b(P_SPP)|b(P_SDT)|b(P_MPRV), '0, b(P_SDT), 2'b00, 0, 0, 0, 1, 1);
      expect_all("R3 R4 R10 sret to S", b(P_SIE)|b(P_SPIE), '0, b(P_SDT), 2'b01, 1'b0);
   endtask

   task automatic t_hold;
      @(negedge clk);
      ms = '1; hs = '1; vs = '1; virt = 1; hyp = 1; dbl = 1; nprv = 2'b00; npv = 1;
      repeat (3) @(negedge clk);
      expect_all("R2 hold without strobe", b(P_SIE)|b(P_SPIE), '0, b(P_SDT), 2'b01, 1'b0);
   endtask

   task automatic t_sret_vu;
      fire(3'b001, 0, b(P_SDT)|b(P_MPRV), b(P_SPV)|b(2), b(P_SDT)|b(0), 2'b00, 0, 1, 1, 1, 0);
      expect_all("R5 R3 R10 sret HS to VU", b(P_SPIE)|b(P_MPRV), b(2), b(0), 2'b00, 1'b1);
   endtask

   task automatic t_sret_virt_on;
      fire(3'b001, 1, b(P_SDT), b(P_SPV), b(P_SDT), 2'b00, 0, 1, 1, 1, 1);
      expect_all("R5 sret while virtualized", b(P_SPIE), '0, b(P_SDT), 2'b00, 1'b1);
      fire(3'b001, 0, b(P_SPP)|b(P_SDT), b(P_SPV), b(P_SDT), 2'b00, 0, 1, 1, 1, 1);
      expect_all("R5 sret HS to VS", b(P_SPIE), '0, b(P_SDT), 2'b01, 1'b1);
   endtask

   task automatic t_sret_nohyp;
      fire(3'b001, 0, '0, b(P_SPV), b(P_SDT), 2'b00, 0, 0, 1, 0, 0);
      expect_all("R3 sret without hypervisor", b(P_SPIE), b(P_SPV), b(P_SDT), 2'b00, 1'b0);
   endtask

   task automatic t_mret;
      fire(3'b010, 0, b(P_MPIE)|b(P_MPRV)|b(P_SDT), '0, b(P_SDT), 2'b00, 0, 0, 1, 1, 1);
      expect_all("R6 R8 R10 mret to U", b(P_MIE)|b(P_MPIE), '0, b(P_SDT), 2'b00, 1'b0);
      fire(3'b010, 0, b(P_MIE)|(64'd3 << P_MPP)|b(P_MPRV)|b(P_SDT), '0, '0, 2'b00, 0, 0, 0, 1, 1);
      expect_all("R6 R10 R8 mret to M no user",
                 b(P_MPIE)|(64'd3 << P_MPP)|b(P_MPRV)|b(P_SDT), '0, '0, 2'b11, 1'b0);
      fire(3'b010, 0, (64'd1 << P_MPP)|b(P_MPV)|b(P_SDT), '0, b(P_SDT), 2'b00, 0, 1, 1, 1, 1);
      expect_all("R8 R9 mret to VS", b(P_MPIE), '0, b(P_SDT), 2'b01, 1'b1);
      fire(3'b010, 0, (64'd1 << P_MPP)|b(P_SDT), '0, '0, 2'b00, 0, 1, 1, 1, 1);
      expect_all("R8 mret to S keeps flag", b(P_MPIE)|b(P_SDT), '0, '0, 2'b01, 1'b0);
      fire(3'b010, 0, b(P_MPV)|b(P_SDT), '0, b(P_SDT)|b(4), 2'b00, 0, 1, 1, 1, 1);
      expect_all("R9 mret to VU", b(P_MPIE), '0, b(4), 2'b00, 1'b1);
   endtask

   task automatic t_mnret;
      fire(3'b100, 0, b(P_SDT)|b(P_MPRV)|b(P_MIE), b(P_SPV), b(P_SDT)|b(4), 2'b00, 1, 1, 1, 1, 0);
      expect_all("R7 R9 R10 nmi return to VU", b(P_MIE), b(P_SPV), b(4), 2'b00, 1'b1);
      fire(3'b100, 0, b(P_SDT)|b(P_MPRV), '0, b(P_SDT), 2'b11, 1, 1, 1, 1, 1);
      expect_all("R7 R10 nmi return to M", b(P_SDT)|b(P_MPRV), '0, b(P_SDT), 2'b11, 1'b0);
      fire(3'b100, 0, b(P_SDT), '0, b(P_SDT), 2'b01, 0, 1, 1, 1, 1);
      expect_all("R8 nmi return to S", b(P_SDT), '0, b(P_SDT), 2'b01, 1'b0);
   endtask

   task automatic t_dbl_off;
      fire(3'b010, 0, b(P_MPV)|b(P_SDT), '0, b(P_SDT), 2'b00, 0, 1, 1, 0, 1);
      expect_all("R11 mret to VU feature off", b(P_MPIE)|b(P_SDT), '0, b(P_SDT), 2'b00, 1'b1);
      fire(3'b001, 0, b(P_SDT), b(P_SPV), b(P_SDT), 2'b00, 0, 1, 1, 0, 1);
      expect_all("R11 sret feature off", b(P_SPIE)|b(P_SDT), '0, b(P_SDT), 2'b00, 1'b1);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      t_reset();
      t_sret_basic();
      t_hold();
      t_sret_vu();
      t_sret_virt_on();
      t_sret_nohyp();
      t_mret();
      t_mnret();
      t_dbl_off();
      done = 1;
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
      end
   end
endmodule